// File: doc/BRIEF.md
# Byte Rotate, Shift and Bit-Manipulation Unit

This unit performs the extended single-operand register operations of a small 8-bit processor datapath. It rotates left or right, either circularly or through the carry flag. It shifts left arithmetically and shifts right arithmetically or logically. It can exchange the two nibbles of the operand. It can also test, set or clear one bit chosen by an index. Each operation has its own rule for the vacated bit, for the carry and for the zero flag. The unit reports a result, a result write strobe, the four flag values and a per-flag write mask, so the register file and flag register need no knowledge of the operation.

A separate group of rotate codes serves the short accumulator-only rotate forms. They produce the same result and carry as the register rotates, but they always clear zero. The operand fetch, any memory access and the instruction decode stay outside the unit. The operation logic is combinational and feeds a single output register, so every answer appears one clock after its inputs. All outputs change every cycle.

Top module: `rsb_unit`

## Requirements
- R1: While the active-low reset is asserted, result, result_we, every flag and flag_we are all 0.
- R2: The outputs present at a rising clock edge describe the inputs sampled at the previous rising edge, and a new input set is accepted on every edge.
- R3: Code 0 rotates left circularly: old bit 7 moves into bit 0 and into carry. Code 2 rotates left through carry: the old carry enters bit 0 and old bit 7 goes to carry.
- R4: Code 1 rotates right circularly: old bit 0 moves into bit 7 and into carry. Code 3 rotates right through carry: the old carry enters bit 7 and old bit 0 goes to carry.
- R5: Code 4 shifts left, fills bit 0 with 0 and sends old bit 7 to carry.
- R6: Code 5 shifts right, keeps bit 7 at its old value and sends old bit 0 to carry.
- R7: Code 6 shifts right, fills bit 7 with 0 and sends old bit 0 to carry.
- R8: Codes 0 to 7 write the result (result_we=1), write all four flags (flag_we=4'b1111, order zero, subtract, half-carry, carry from MSB down), set zero only when the result is 0 and clear subtract and half-carry.
- R9: Codes 8, 9, 10 and 11 give the same result and carry as codes 0, 1, 2 and 3, write result and all flags, clear subtract and half-carry, and always clear zero.
- R10: Code 7 exchanges bits 7..4 with bits 3..0, sets zero only on a zero result and clears carry.
- R11: Code 12 tests the bit picked by bit_idx (0 is the rightmost bit). Zero is set when that bit is 0, half-carry is 1 and subtract is 0. flag_we is 4'b1110, so carry is not written. result_we is 0 and result shows the operand.
- R12: Codes 13 and 14 force the indexed bit to 1 or 0 and leave every other bit unchanged. They write the result with flag_we=4'b0000. An unwritten flag reads 0.
- R13: Code 15 is reserved: result_we=0, flag_we=4'b0000, every flag 0, and result shows the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation code (see requirements) |
| operand | input | DATA_W (8) | Value to operate on |
| bit_idx | input | IDX_W (3) | Bit index for test, set and clear |
| carry_in | input | 1 | Current carry flag |
| result | output | DATA_W (8) | Registered result value |
| result_we | output | 1 | Result should be written back |
| flag_z | output | 1 | Zero flag value |
| flag_n | output | 1 | Subtract flag value |
| flag_h | output | 1 | Half-carry flag value |
| flag_c | output | 1 | Carry flag value |
| flag_we | output | 4 | Per-flag write mask: zero, subtract, half-carry, carry |

## Verification
The clocked properties assume that op_sel, operand, bit_idx and carry_in hold known values at every rising edge once reset is released, and they compare the outputs with the inputs of the edge before. The stimulus therefore drives every input to a defined value from time zero and changes inputs only at falling edges. It covers all sixteen operation codes, so no undefined code reaches the unit. The operand patterns are chosen to hit the rotate and shift boundaries: both end bits set, a single end bit set, all zeros and all ones. Each pattern is applied with both carry values and with every bit index.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    typedef enum logic [3:0] {
        OP_ROL_CIRC   = 4'd0,
        OP_ROR_CIRC   = 4'd1,
        OP_ROL_CARRY  = 4'd2,
        OP_ROR_CARRY  = 4'd3,
        OP_SHL_ARITH  = 4'd4,
        OP_SHR_ARITH  = 4'd5,
        OP_SHR_LOGIC  = 4'd6,
        OP_NIB_SWAP   = 4'd7,
        OP_AROL_CIRC  = 4'd8,
        OP_AROR_CIRC  = 4'd9,
        OP_AROL_CARRY = 4'd10,
        OP_AROR_CARRY = 4'd11,
        OP_BIT_TEST   = 4'd12,
        OP_BIT_SET    = 4'd13,
        OP_BIT_CLR    = 4'd14,
        OP_RESERVED   = 4'd15
    } rsb_op_t;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } rsb_flags_t;

    localparam logic [3:0] FWE_ALL  = 4'b1111;
    localparam logic [3:0] FWE_NO_C = 4'b1110;
    localparam logic [3:0] FWE_NONE = 4'b0000;

    // Accumulator-only rotate group: same data path, zero forced clear.
    function automatic logic is_acc_rot(rsb_op_t op);
        return (op == OP_AROL_CIRC) || (op == OP_AROR_CIRC) ||
               (op == OP_AROL_CARRY) || (op == OP_AROR_CARRY);
    endfunction

    // Every code served by the shifter (register forms, swap, acc rotates).
    function automatic logic is_shift_grp(rsb_op_t op);
        return (op <= OP_AROR_CARRY);
    endfunction

endpackage

// File: rtl/rsb_shift.sv
module rsb_shift
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rsb_op_t            op,
    input  logic [DATA_W-1:0]  opd,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  res,
    output logic               carry_out
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = DATA_W - 1;

    logic [DATA_W-1:0] swapped;
    rsb_op_t           base_op;

    // Nibble exchange built per bit pair.
    generate
        for (genvar g = 0; g < HALF_W; g++) begin : g_swap
            assign swapped[g]          = opd[g + HALF_W];
            assign swapped[g + HALF_W] = opd[g];
        end
    endgenerate

    // Accumulator rotates share the register-form rotate datapath.
    always_comb begin
        base_op = op;
        if (is_acc_rot(op)) begin
            base_op = rsb_op_t'({2'b00, op[1:0]});
        end
    end

    always_comb begin
        res       = opd;
        carry_out = 1'b0;
        case (base_op)
            OP_ROL_CIRC: begin
                res       = {opd[MSB-1:0], opd[MSB]};
                carry_out = opd[MSB];
            end
            OP_ROL_CARRY: begin
                res       = {opd[MSB-1:0], carry_in};
                carry_out = opd[MSB];
            end
            OP_SHL_ARITH: begin
                res       = {opd[MSB-1:0], 1'b0};
                carry_out = opd[MSB];
            end
            OP_ROR_CIRC: begin
                res       = {opd[0], opd[MSB:1]};
                carry_out = opd[0];
            end
            OP_ROR_CARRY: begin
                res       = {carry_in, opd[MSB:1]};
                carry_out = opd[0];
            end
            OP_SHR_ARITH: begin
                res       = {opd[MSB], opd[MSB:1]};
                carry_out = opd[0];
            end
            OP_SHR_LOGIC: begin
                res       = {1'b0, opd[MSB:1]};
                carry_out = opd[0];
            end
            OP_NIB_SWAP: begin
                res       = swapped;
                carry_out = 1'b0;
            end
            default: begin
                res       = opd;
                carry_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  rsb_op_t            op,
    input  logic [DATA_W-1:0]  opd,
    input  logic [IDX_W-1:0]   idx,
    output logic [DATA_W-1:0]  res,
    output logic               sel_is_zero
);
    logic [DATA_W-1:0] sel_mask;

    // One-hot decode of the bit index.
    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_dec
            assign sel_mask[g] = (idx == IDX_W'(g));
        end
    endgenerate

    assign sel_is_zero = ~|(opd & sel_mask);

    always_comb begin
        case (op)
            OP_BIT_SET: res = opd | sel_mask;
            OP_BIT_CLR: res = opd & ~sel_mask;
            default:    res = opd;
        endcase
    end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int HALF_W = DATA_W / 2,
    localparam int MSB    = DATA_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         op_sel,
    input  logic [DATA_W-1:0]  operand,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  result,
    output logic               result_we,
    output logic               flag_z,
    output logic               flag_n,
    output logic               flag_h,
    output logic               flag_c,
    output logic [3:0]         flag_we
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        rsb_flags_t        fl;
        logic [3:0]        fwe;
    } rsb_out_t;

    rsb_op_t           op;
    logic [DATA_W-1:0] sh_res;
    logic              sh_carry;
    logic [DATA_W-1:0] bo_res;
    logic              bo_zero;
    rsb_out_t          out_d;
    rsb_out_t          out_q;

    assign op = rsb_op_t'(op_sel);

    rsb_shift #(.DATA_W(DATA_W)) u_shift (
        .op        (op),
        .opd       (operand),
        .carry_in  (carry_in),
        .res       (sh_res),
        .carry_out (sh_carry)
    );

    rsb_bitop #(.DATA_W(DATA_W)) u_bitop (
        .op          (op),
        .opd         (operand),
        .idx         (bit_idx),
        .res         (bo_res),
        .sel_is_zero (bo_zero)
    );

    always_comb begin
        out_d     = '0;
        out_d.res = operand;
        if (is_shift_grp(op)) begin
            out_d.res  = sh_res;
            out_d.we   = 1'b1;
            out_d.fl.z = is_acc_rot(op) ? 1'b0 : (sh_res == '0);
            out_d.fl.c = sh_carry;
            out_d.fwe  = FWE_ALL;
        end else if (op == OP_BIT_TEST) begin
            out_d.fl.z = bo_zero;
            out_d.fl.h = 1'b1;
            out_d.fwe  = FWE_NO_C;
        end else if ((op == OP_BIT_SET) || (op == OP_BIT_CLR)) begin
            out_d.res = bo_res;
            out_d.we  = 1'b1;
            out_d.fwe = FWE_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result    = out_q.res;
    assign result_we = out_q.we;
    assign flag_z    = out_q.fl.z;
    assign flag_n    = out_q.fl.n;
    assign flag_h    = out_q.fl.h;
    assign flag_c    = out_q.fl.c;
    assign flag_we   = out_q.fwe;

    // Port-level view of the indexed bit, used by the bit-test check.
    logic idx_bit_now;
    assign idx_bit_now = operand[bit_idx];

    assert_shift_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel <= 4'd11) |=> (result_we && !flag_n && !flag_h && flag_we == 4'b1111));

    assert_acc_zero_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[3:2] == 2'b10) |=> !flag_z);

    assert_sra_keeps_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd5) |=> (result[MSB] == $past(operand[MSB]) && flag_c == $past(operand[0])));

    assert_swap_nibbles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd7) |=> (!flag_c &&
            result == {$past(operand[HALF_W-1:0]), $past(operand[DATA_W-1:HALF_W])}));

    assert_bit_test_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd12) |=> (!result_we && flag_h && !flag_n && flag_we == 4'b1110 &&
            flag_z == !$past(idx_bit_now)));

    assert_bit_write_one_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_sel == 4'd13) || (op_sel == 4'd14)) |=>
            (result_we && flag_we == 4'b0000 && $countones(result ^ $past(operand)) <= 1));

    assert_reserved_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd15) |=> (!result_we && flag_we == 4'b0000));

endmodule

// File: tb/rsb_unit_bench.sv
module rsb_unit_bench;

    typedef struct {
        logic [7:0] res;
        logic       we;
        logic [3:0] fl;
        logic [3:0] fwe;
        string      req;
        int         op;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] operand = 8'd0;
    logic [2:0] bit_idx = 3'd0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       result_we;
    logic       flag_z, flag_n, flag_h, flag_c;
    logic [3:0] flag_we;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    rsb_unit u_rsb_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .operand   (operand),
        .bit_idx   (bit_idx),
        .carry_in  (carry_in),
        .result    (result),
        .result_we (result_we),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_h    (flag_h),
        .flag_c    (flag_c),
        .flag_we   (flag_we)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference behaviour written from the requirement list.
    function automatic exp_t model(int op, logic [7:0] a, int idx, logic cin);
        exp_t e;
        logic z, n, h, c;
        e.res = a; e.we = 1'b0; e.fwe = 4'b0000; e.op = op;
        z = 1'b0; n = 1'b0; h = 1'b0; c = 1'b0;
        case (op % 8)
            0: begin e.res = 8'((a << 1) | (a >> 7));   c = a[7]; e.req = "R3"; end
            1: begin e.res = 8'((a >> 1) | (a << 7));   c = a[0]; e.req = "R4"; end
            2: begin e.res = 8'((a << 1) | 8'(cin));    c = a[7]; e.req = "R3"; end
            3: begin e.res = 8'((a >> 1) | (8'(cin) << 7)); c = a[0]; e.req = "R4"; end
            default: ;
        endcase
        if (op <= 11) begin
            case (op)
                4: begin e.res = 8'(a << 1); c = a[7]; e.req = "R5"; end
                5: begin e.res = 8'((a >> 1) | (a & 8'h80)); c = a[0]; e.req = "R6"; end
                6: begin e.res = 8'(a >> 1); c = a[0]; e.req = "R7"; end
                7: begin e.res = {a[3:0], a[7:4]}; c = 1'b0; e.req = "R10"; end
                default: ;
            endcase
            if (op >= 8) e.req = "R9";
            z = (op >= 8) ? 1'b0 : (e.res == 8'h00);
            e.we = 1'b1; e.fwe = 4'b1111;
        end else if (op == 12) begin
            z = ~a[idx]; h = 1'b1; e.fwe = 4'b1110; e.req = "R11";
        end else if (op == 13) begin
            e.res = a | 8'(1 << idx); e.we = 1'b1; e.req = "R12";
        end else if (op == 14) begin
            e.res = a & ~8'(1 << idx); e.we = 1'b1; e.req = "R12";
        end else begin
            e.req = "R13";
        end
        e.fl = {z, n, h, c};
        return e;
    endfunction

    // Driver: one input set per falling edge, expected item queued.
    task automatic drive(int op, logic [7:0] a, int idx, logic cin);
        @(negedge clk);
        op_sel   = 4'(op);
        operand  = a;
        bit_idx  = 3'(idx);
        carry_in = cin;
        sb_q.push_back(model(op, a, idx, cin));
    endtask

    // Monitor: result of the previous edge's inputs, sampled after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({"R2/", e.req, " result"}, 32'(result), 32'(e.res));
            check({e.req, " write strobes"}, 32'({result_we, flag_we}), 32'({e.we, e.fwe}));
            check({(e.op <= 6) ? "R8" : e.req, " flags"},
                  32'({flag_z, flag_n, flag_h, flag_c}), 32'(e.fl));
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [8];
        pats = '{8'h00, 8'h01, 8'h80, 8'h81, 8'hA5, 8'h5A, 8'hFF, 8'h7E};

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 result", 32'(result), 32'h0);
        check("R1 strobes", 32'({result_we, flag_we}), 32'h0);
        check("R1 flags", 32'({flag_z, flag_n, flag_h, flag_c}), 32'h0);
        rst_n = 1'b1;

        // Directed corners: SRA with both ends set, acc rotate giving zero.
        drive(5, 8'h81, 0, 1'b0);   // R6: 0xC0, carry 1
        drive(9, 8'h00, 0, 1'b1);   // R9: zero result, zero flag still clear
        drive(2, 8'h80, 0, 1'b0);   // R3: result 0, zero set, carry 1
        drive(3, 8'h01, 0, 1'b1);   // R4: carry into bit 7 gives 0x80
        drive(12, 8'hFE, 0, 1'b1);  // R11: bit 0 clear
        drive(13, 8'h00, 7, 1'b0);  // R12: leftmost bit

        // Sweep of every code, pattern and carry value.
        for (int op = 0; op < 16; op++) begin
            for (int p = 0; p < 8; p++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    if (op >= 12 && op <= 14) begin
                        for (int ix = 0; ix < 8; ix++) begin
                            drive(op, pats[p], ix, ci[0]);
                        end
                    end else begin
                        drive(op, pats[p], p, ci[0]);
                    end
                end
            end
        end

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule